// File: doc/BRIEF.md
# Pulse-gap downlink encoder

This block keys a 125 kHz reader field on and off so that a bit string reaches a read/write tag on the reader-to-tag link. It does not count time itself: every duration is measured in carrier-cycle ticks, one tick per carrier cycle (8 µs at 125 kHz), supplied by the surrounding logic as a one-clock strobe. A command is launched with a start strobe together with a bit count of up to 64 and a bit vector.

The first bit of every command is spent on a long lead-in gap whatever its value. Each later bit is sent from the vector in ascending index order. A 1 leaves the field on for one unbroken period. A 0 makes a short gap followed by a fixed on-time. After the last bit the field stays on for a response window that is picked per command: a short one suits a read, a long one suits a write. When that window closes, a one-clock done pulse is issued and the block is ready for the next command. Building the command and address bits and decoding the tag's answer are left to neighbouring logic.

Top module: `pulse_gap_downlink`

## Requirements
- R1: While reset is high and afterwards when idle, `field_en` is 1 (field on) and `done` is 0; a reset during a command returns the block to this idle state at once.
- R2: A start accepted while idle drives `field_en` to 0 from the next clock for exactly 55 ticks, then to 1 for 18 ticks; the value of `bits[0]` has no effect on this lead-in.
- R3: Each bit after the lead-in whose value is 1 holds `field_en` at 1 for exactly 32 ticks.
- R4: Each bit after the lead-in whose value is 0 drives `field_en` to 0 for exactly 23 ticks and then to 1 for 18 ticks.
- R5: With N = `bit_count`, the bits sent after the lead-in are `bits[1]` up to `bits[N-1]` in ascending index order; N of 0 or 1 sends only the lead-in, and bits at index N or above have no effect.
- R6: After the last bit's on-time the field stays on for a further 50 ticks when `wait_sel` was 0 at the accepted start (read window) or 813 ticks when it was 1 (write window).
- R7: `done` is 1 for exactly one clock, in the clock in which the response window ends, with `field_en` at 1 in that clock and afterwards.
- R8: A start while a command is in progress, including one in the clock where the response window ends, is ignored; a start in the clock where `done` is 1 is accepted.
- R9: All durations advance only on clocks where `tick` is 1; while `tick` stays 0 a running command keeps its `field_en` level.
- R10: A `bit_count` above 64 behaves as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock strobe per carrier cycle |
| start | input | 1 | Launches a command when idle |
| wait_sel | input | 1 | Response window: 0 read (short), 1 write (long) |
| bit_count | input | 7 | Number of command bits including the lead-in bit |
| bits | input | 64 | Command bits, index 0 first |
| field_en | output | 1 | 1 = reader field on, 0 = field off |
| done | output | 1 | One-clock pulse when the response window ends |

## Verification
The end of the response window and a fresh start strobe can land in the same clock. The bench provokes this by raising start so that it is sampled on the very edge that closes the window. The run must still finish with a single done pulse and the field on, and no new lead-in gap may appear. It also raises start in the clock where done is visible and requires that the next command begins with its lead-in gap right away. Apart from that, every command's field waveform is cut into on and off runs measured in ticks and compared with runs built from the bit vector, including a run with sparse ticks.

// File: rtl/dlk_pkg.sv
package dlk_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_LEAD_OFF = 3'd1,
    PH_LEAD_ON  = 3'd2,
    PH_ONE_ON   = 3'd3,
    PH_ZERO_OFF = 3'd4,
    PH_ZERO_ON  = 3'd5,
    PH_POST     = 3'd6
  } phase_t;

  // Field level belonging to each phase: only the two gap phases switch it off.
  function automatic logic field_on(input phase_t p);
    return !((p == PH_LEAD_OFF) || (p == PH_ZERO_OFF));
  endfunction

  function automatic int dlk_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dlk_tick_timer.sv
// Down counter advanced by the carrier tick; a phase lasting D ticks is loaded with D-1.
module dlk_tick_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = tick && (cnt_q == '0);

  // R9: without a tick or a reload the remaining time does not move.
  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/dlk_bit_feed.sv
// Holds the command bits still to be sent; index 0 is dropped at capture (lead-in).
module dlk_bit_feed #(
  parameter int MAX_BITS = 64,
  parameter int CNT_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic                advance,
  input  logic [MAX_BITS-1:0] bits_in,
  input  logic [CNT_W-1:0]    count_in,
  output logic                cur_bit,
  output logic                more
);

  logic [MAX_BITS-1:0] sh_q;
  logic [CNT_W-1:0]    left_q;
  logic [CNT_W-1:0]    eff_cnt;

  // R10: counts beyond the vector width are clamped.
  always_comb begin
    if (count_in > CNT_W'(MAX_BITS)) eff_cnt = CNT_W'(MAX_BITS);
    else                             eff_cnt = count_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (capture) begin
      sh_q   <= bits_in >> 1;
      left_q <= (eff_cnt == '0) ? '0 : eff_cnt - 1'b1;
    end else if (advance) begin
      sh_q   <= sh_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign cur_bit = sh_q[0];
  assign more    = (left_q != '0);

  // R5: a bit is only taken while bits remain.
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    advance |-> (left_q != '0));

  // R10: never more than MAX_BITS-1 bits follow the lead-in.
  p_left_bound_r10: assert property (@(posedge clk) disable iff (rst)
    left_q <= CNT_W'(MAX_BITS - 1));

endmodule

// File: rtl/dlk_phase_ctrl.sv
module dlk_phase_ctrl
  import dlk_pkg::*;
#(
  parameter int CW           = 10,
  parameter int LEAD_OFF_T   = 55,
  parameter int LEAD_ON_T    = 18,
  parameter int ONE_T        = 32,
  parameter int ZERO_OFF_T   = 23,
  parameter int ZERO_ON_T    = 18,
  parameter int READ_WAIT_T  = 50,
  parameter int WRITE_WAIT_T = 813
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wait_sel,
  input  logic          expire,
  input  logic          cur_bit,
  input  logic          more,
  output logic          capture,
  output logic          advance,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          field_en,
  output logic          done
);

  phase_t phase_q, phase_d;
  logic   wsel_q;
  logic   fin;
  logic   field_q;
  logic   done_q;

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    advance  = 1'b0;
    fin      = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d  = PH_LEAD_OFF;
          load     = 1'b1;
          load_val = CW'(LEAD_OFF_T - 1);
          capture  = 1'b1;
        end
      end
      PH_LEAD_OFF: begin
        if (expire) begin
          phase_d  = PH_LEAD_ON;
          load     = 1'b1;
          load_val = CW'(LEAD_ON_T - 1);
        end
      end
      PH_ZERO_OFF: begin
        if (expire) begin
          phase_d  = PH_ZERO_ON;
          load     = 1'b1;
          load_val = CW'(ZERO_ON_T - 1);
        end
      end
      PH_LEAD_ON, PH_ONE_ON, PH_ZERO_ON: begin
        if (expire) begin
          load = 1'b1;
          if (more) begin
            advance = 1'b1;
            if (cur_bit) begin
              phase_d  = PH_ONE_ON;
              load_val = CW'(ONE_T - 1);
            end else begin
              phase_d  = PH_ZERO_OFF;
              load_val = CW'(ZERO_OFF_T - 1);
            end
          end else begin
            phase_d  = PH_POST;
            load_val = wsel_q ? CW'(WRITE_WAIT_T - 1) : CW'(READ_WAIT_T - 1);
          end
        end
      end
      PH_POST: begin
        if (expire) begin
          phase_d = PH_IDLE;
          fin     = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      wsel_q  <= 1'b0;
      field_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      field_q <= field_on(phase_d);
      done_q  <= fin;
      if (capture) wsel_q <= wait_sel;
    end
  end

  assign field_en = field_q;
  assign done     = done_q;

  // R2: an accepted start opens the lead-in gap on the next clock.
  p_lead_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && start) |=> (phase_q == PH_LEAD_OFF && !field_en));

  // R7: done lasts one clock, with the field on and the block idle.
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_field_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (field_en && phase_q == PH_IDLE));

  // R8 / R9: a busy block moves only on an expiring tick, whatever start does.
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && !expire) |=> ($stable(phase_q) && $stable(field_en)));

endmodule

// File: rtl/pulse_gap_downlink.sv
module pulse_gap_downlink #(
  parameter int MAX_BITS     = 64,
  parameter int LEAD_OFF_T   = 55,
  parameter int LEAD_ON_T    = 18,
  parameter int ONE_T        = 32,
  parameter int ZERO_OFF_T   = 23,
  parameter int ZERO_ON_T    = 18,
  parameter int READ_WAIT_T  = 50,
  parameter int WRITE_WAIT_T = 813,
  localparam int CNT_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                start,
  input  logic                wait_sel,
  input  logic [CNT_W-1:0]    bit_count,
  input  logic [MAX_BITS-1:0] bits,
  output logic                field_en,
  output logic                done
);

  import dlk_pkg::*;

  localparam int MAX_A   = dlk_max(dlk_max(LEAD_OFF_T, LEAD_ON_T), dlk_max(ONE_T, ZERO_OFF_T));
  localparam int MAX_B   = dlk_max(dlk_max(ZERO_ON_T, READ_WAIT_T), WRITE_WAIT_T);
  localparam int MAX_DUR = dlk_max(MAX_A, MAX_B);
  localparam int CW      = $clog2(MAX_DUR + 1);

  logic          expire;
  logic          load;
  logic [CW-1:0] load_val;
  logic          capture;
  logic          advance;
  logic          cur_bit;
  logic          more;

  dlk_tick_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (load),
    .load_val (load_val),
    .expire   (expire)
  );

  dlk_bit_feed #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_feed (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .advance  (advance),
    .bits_in  (bits),
    .count_in (bit_count),
    .cur_bit  (cur_bit),
    .more     (more)
  );

  dlk_phase_ctrl #(
    .CW           (CW),
    .LEAD_OFF_T   (LEAD_OFF_T),
    .LEAD_ON_T    (LEAD_ON_T),
    .ONE_T        (ONE_T),
    .ZERO_OFF_T   (ZERO_OFF_T),
    .ZERO_ON_T    (ZERO_ON_T),
    .READ_WAIT_T  (READ_WAIT_T),
    .WRITE_WAIT_T (WRITE_WAIT_T)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wait_sel (wait_sel),
    .expire   (expire),
    .cur_bit  (cur_bit),
    .more     (more),
    .capture  (capture),
    .advance  (advance),
    .load     (load),
    .load_val (load_val),
    .field_en (field_en),
    .done     (done)
  );

  // R1: the field is on whenever no command holds it off, so done never meets a gap.
  p_done_field_on_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> field_en);

endmodule

// File: tb/test_pulse_gap_downlink.sv
`timescale 1ns/1ps
module test_pulse_gap_downlink;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic        wait_sel = 1'b0;
  logic [6:0]  bit_count = '0;
  logic [63:0] bits = '0;
  logic        field_en;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int tick_per = 1;
  int tph = 0;

  int exp_len [256];
  int exp_n;
  int got_len [256];
  int got_n;

  localparam int T_LEAD_OFF = 55;
  localparam int T_LEAD_ON  = 18;
  localparam int T_ONE      = 32;
  localparam int T_ZOFF     = 23;
  localparam int T_ZON      = 18;
  localparam int T_READ     = 50;
  localparam int T_WRITE    = 813;

  // Stimulus table: bits, count, window select, expected gap count, mid start, end collision.
  localparam int NV = 8;
  localparam logic [63:0] TV_BITS [NV] = '{
    64'h0000_0000_0000_00A5, 64'h0000_0000_0000_00FF, 64'h0,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
    64'h0000_0000_0000_001E, 64'h5555_5555_5555_5555,   // R10: count 127
    64'hFFFF_FFFF_FFFF_FFF2};
  localparam int TV_CNT  [NV] = '{8, 1, 0, 64, 64, 5, 127, 3};
  localparam bit TV_WS   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam int TV_GAPS [NV] = '{5, 1, 1, 1, 64, 1, 33, 2};
  localparam int TV_MID  [NV] = '{30, 0, 0, 0, 0, 0, 0, 0};
  localparam bit TV_COLL [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  pulse_gap_downlink i_pulse_gap_downlink (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .wait_sel(wait_sel),
    .bit_count(bit_count), .bits(bits), .field_en(field_en), .done(done)
  );

  always #5 clk = ~clk;

  // Tick strobe, changed just after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (tick_per == 0) begin
        tick = 1'b0;
      end else begin
        tick = (tph == 0);
        tph  = (tph + 1 >= tick_per) ? 0 : tph + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Expected alternating runs (off first), in ticks, from the requirements.
  task automatic build_exp(input int cnt, input logic [63:0] b, input bit ws);
    int eff;
    int on_len;
    eff = (cnt > 64) ? 64 : cnt;
    exp_len[0] = T_LEAD_OFF;
    exp_n  = 1;
    on_len = T_LEAD_ON;
    for (int i = 1; i < eff; i++) begin
      if (b[i]) begin
        on_len = on_len + T_ONE;
      end else begin
        exp_len[exp_n] = on_len;
        exp_n = exp_n + 1;
        exp_len[exp_n] = T_ZOFF;
        exp_n = exp_n + 1;
        on_len = T_ZON;
      end
    end
    on_len = on_len + (ws ? T_WRITE : T_READ);
    exp_len[exp_n] = on_len;
    exp_n = exp_n + 1;
  endtask

  task automatic run_cmd(input int cnt, input logic [63:0] b, input bit ws, input int gaps,
                         input int mid_at, input bit coll, input bit post_chk);
    logic cur;
    int   len;
    int   steps;
    string tag;
    build_exp(cnt, b, ws);
    bit_count = cnt[6:0];
    bits      = b;
    wait_sel  = ws;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cur = 1'b0; len = 0; got_n = 0; steps = 0;
    while (!done && steps < 30000) begin
      if (field_en !== cur) begin
        if (got_n < 255) begin got_len[got_n] = len; got_n++; end
        cur = field_en;
        len = 0;
      end
      if (tick) len++;
      if (mid_at != 0 && steps == mid_at) start = 1'b1;
      if (coll && cur == 1'b1 && got_n == exp_n - 1 && len == exp_len[exp_n-1]) start = 1'b1;
      steps++;
      @(negedge clk);
      start = 1'b0;
    end
    if (steps >= 30000) begin
      chk(1'b0, "R7 done missing", 0, 1);
    end else begin
      got_len[got_n] = len;
      got_n++;
      chk(field_en === 1'b1, "R7 field at done", int'(field_en), 1);
      chk(got_n == exp_n, "R5 run count", got_n, exp_n);
      chk((got_n + 1) / 2 == gaps, "R5 gap count", (got_n + 1) / 2, gaps);
      for (int i = 0; i < got_n && i < exp_n; i++) begin
        if (i == 0)              tag = "R2 lead gap";
        else if (i == exp_n - 1) tag = "R6 final on-time";
        else if (i % 2 == 1)     tag = "R3 on run";
        else                     tag = "R4 zero gap";
        chk(got_len[i] == exp_len[i], tag, got_len[i], exp_len[i]);
      end
      if (post_chk) begin
        @(negedge clk);
        chk(done === 1'b0, "R7 done one clock", int'(done), 0);
        chk(field_en === 1'b1, "R8 stays idle on", int'(field_en), 1);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(field_en === 1'b1, "R1 field in reset", int'(field_en), 1);
    chk(done === 1'b0, "R1 done in reset", int'(done), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(field_en === 1'b1, "R1 idle field", int'(field_en), 1);

    // Table walk: R2..R7, R8 (mid start and end collision), R10.
    for (int v = 0; v < NV; v++) begin
      run_cmd(TV_CNT[v], TV_BITS[v], TV_WS[v], TV_GAPS[v], TV_MID[v], TV_COLL[v], 1'b1);
      repeat (2) @(negedge clk);
    end

    // R9: sparse ticks give the same run lengths in ticks.
    tick_per = 3;
    run_cmd(TV_CNT[0], TV_BITS[0], 1'b1, TV_GAPS[0], 0, 1'b0, 1'b1);
    tick_per = 1;
    repeat (2) @(negedge clk);

    // R8: start in the done clock is accepted back to back.
    run_cmd(TV_CNT[7], TV_BITS[7], 1'b0, TV_GAPS[7], 0, 1'b0, 1'b0);
    run_cmd(TV_CNT[5], TV_BITS[5], 1'b1, TV_GAPS[5], 0, 1'b0, 1'b1);

    // R9: with no tick a gap never ends.
    tick_per = 0;
    @(negedge clk);
    bit_count = 7'd4; bits = 64'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    chk(field_en === 1'b0, "R9 held gap", int'(field_en), 0);
    chk(done === 1'b0, "R9 no done", int'(done), 0);

    // R1: reset in the middle of a command.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(field_en === 1'b1, "R1 mid reset field", int'(field_en), 1);
    chk(done === 1'b0, "R1 mid reset done", int'(done), 0);
    tick_per = 1;
    repeat (2) @(negedge clk);
    run_cmd(TV_CNT[1], TV_BITS[1], 1'b0, TV_GAPS[1], 0, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule